// File: doc/BRIEF.md
# Serial Peripheral Interrupt Status Aggregator

This block collects the interrupt events of a four-channel serial peripheral into one status register and drives a single level-sensitive interrupt line. Every channel raises two kinds of single-cycle event pulse: one when its transmit holding slot empties and one when its receive slot fills. Each pulse sets a fixed status bit. An enable register selects which status bits reach the interrupt output.

Software acknowledges an interrupt by writing ones to the status bits it wants cleared. The block also holds a test register and a module-control register, and together they form a system-test mode. When the test bit of module control and the strobe bit of the test register are both set, every implemented status bit is forced to one. Software clears then have no effect until one of the two bits drops. Register writes arrive as one-cycle strobes with a shared data word. The current register contents are brought out on ports so that a bus wrapper can return them on reads.

Top module: `spi_irq_aggregator`

## Requirements
- R1: `irq_o` is high exactly when some bit is set in both `status_o` and `enable_o`.
- R2: A `tx_empty_evt_i[n]` pulse sets status bit 4n and a `rx_full_evt_i[n]` pulse sets status bit 4n+2, visible the cycle after the pulse.
- R3: A status write clears every status bit whose `wdata_i` bit is one and leaves every other bit unchanged.
- R4: While module-control bit 3 and test-register bit 11 are both set, status writes clear nothing.
- R5: The implemented bit mask is 0x1777F. The enable register stores `wdata_i` ANDed with this mask, and status bits outside it always read zero.
- R6: A test-register write with `wdata_i` bit 11 set, made while module-control bit 3 is set, sets the status register to 0x1777F.
- R7: A module-control write with `wdata_i` bit 3 set, made while test-register bit 11 is already set, sets the status register to 0x1777F. Without bit 11 already set, the same write forces nothing.
- R8: The test register stores `wdata_i[11:0]` and module control stores `wdata_i[3:0]`.
- R9: When a channel event and a status write that clears the same bit happen in the same cycle, the bit ends up set.
- R10: After reset, status, enable and test read 0, module control reads 0x4 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_empty_evt_i | input | 4 | Per-channel transmit-empty event pulse |
| rx_full_evt_i | input | 4 | Per-channel receive-full event pulse |
| wdata_i | input | 17 | Write data shared by all register strobes |
| stat_we_i | input | 1 | Status write strobe (write one to clear) |
| en_we_i | input | 1 | Enable register write strobe |
| test_we_i | input | 1 | Test register write strobe |
| mode_we_i | input | 1 | Module-control register write strobe |
| status_o | output | 17 | Interrupt status register |
| enable_o | output | 17 | Interrupt enable register |
| test_o | output | 12 | Test register |
| mode_o | output | 4 | Module-control register |
| irq_o | output | 1 | Level interrupt output |

## Verification
The hardest state to reach is the window in which the clear is blocked. It exists only after two writes to different registers, and these must come in an order that also decides whether a force happens. The bench enters the window from both sides. In one case it sets the test bit first and then writes the strobe bit, so the test-register write forces the status. In the other it sets the strobe bit while test mode is off, which forces nothing, and then turns test mode on, so the module-control write forces the status. Inside the window the bench writes a clear of all ones and reads the status back unchanged. It then leaves the window and shows that the same clear works again.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STAT_W      = 17;
  localparam logic [STAT_W-1:0] IMPL_MASK = 17'h1777F;
  localparam int TEST_W      = 12;
  localparam int MODE_W      = 4;
  localparam logic [MODE_W-1:0] MODE_RST = 4'h4;
  localparam int SYSTEST_BIT = 3;
  localparam int STROBE_BIT  = 11;
  localparam int CH_STRIDE   = 4;
  localparam int TX_OFS      = 0;
  localparam int RX_OFS      = 2;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEST_W-1:0] wdata_i,
  input  logic              test_we_i,
  input  logic              mode_we_i,
  output logic [TEST_W-1:0] test_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              force_o,
  output logic              clr_block_o
);
  logic [TEST_W-1:0] test_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= '0;
      mode_q <= MODE_RST;
    end else begin
      if (test_we_i) test_q <= wdata_i;
      if (mode_we_i) mode_q <= wdata_i[MODE_W-1:0];
    end
  end

  // force is evaluated against the other register's value before this write
  always_comb begin
    force_o = (test_we_i && mode_q[SYSTEST_BIT] && wdata_i[STROBE_BIT]) ||
              (mode_we_i && wdata_i[SYSTEST_BIT] && test_q[STROBE_BIT]);
  end

  assign clr_block_o = mode_q[SYSTEST_BIT] && test_q[STROBE_BIT];
  assign test_o      = test_q;
  assign mode_o      = mode_q;

  assert_mode_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == $past(wdata_i[MODE_W-1:0])));
  assert_test_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_we_i |=> (test_o == $past(wdata_i)));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_vec_i,
  input  logic              force_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic              clr_block_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] status_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                          status_q[i] <= 1'b0;
        else if (evt_vec_i[i] || force_i)                     status_q[i] <= 1'b1;
        else if (clr_we_i && clr_data_i[i] && !clr_block_i)   status_q[i] <= 1'b0;
      end
    end else begin : g_none
      assign status_q[i] = 1'b0;
    end
  end

  assign status_o = status_q;

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vec_i != '0) |=> ((status_q & $past(evt_vec_i)) == $past(evt_vec_i)));
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !clr_block_i && !force_i) |=>
      ((status_q & $past(clr_data_i & ~evt_vec_i)) == '0));
  assert_clear_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_block_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_force_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (status_q == IMPL_MASK));
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] enable_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i & IMPL_MASK;
  end

  assign enable_o = en_q;
  assign irq_o    = |(status_i & en_q);

  assert_enable_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (enable_o == ($past(wdata_i) & IMPL_MASK)));
endmodule

// File: rtl/spi_irq_aggregator.sv
module spi_irq_aggregator
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tx_empty_evt_i,
  input  logic [NUM_CH-1:0] rx_full_evt_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              stat_we_i,
  input  logic              en_we_i,
  input  logic              test_we_i,
  input  logic              mode_we_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic [TEST_W-1:0] test_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] evt_vec;
  logic              force_all;
  logic              clr_block;

  always_comb begin
    evt_vec = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      evt_vec[CH_STRIDE*n + TX_OFS] = tx_empty_evt_i[n];
      evt_vec[CH_STRIDE*n + RX_OFS] = rx_full_evt_i[n];
    end
  end

  irq_ctrl_regs u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wdata_i     (wdata_i[TEST_W-1:0]),
    .test_we_i   (test_we_i),
    .mode_we_i   (mode_we_i),
    .test_o      (test_o),
    .mode_o      (mode_o),
    .force_o     (force_all),
    .clr_block_o (clr_block)
  );

  irq_status_reg u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_vec_i   (evt_vec),
    .force_i     (force_all),
    .clr_we_i    (stat_we_i),
    .clr_data_i  (wdata_i),
    .clr_block_i (clr_block),
    .status_o    (status_o)
  );

  irq_mask_out u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (en_we_i),
    .wdata_i  (wdata_i),
    .status_i (status_o),
    .enable_o (enable_o),
    .irq_o    (irq_o)
  );

  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_evt_i[0] && stat_we_i) |=> status_o[TX_OFS]);
endmodule

// File: tb/sim_spi_irq_aggregator.sv
module sim_spi_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] MASK = 17'h1777F;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tx_evt = '0, rx_evt = '0;
  logic [16:0] wdata = '0;
  logic        stat_we = 0, en_we = 0, test_we = 0, mode_we = 0;
  logic [16:0] status, enable;
  logic [11:0] test;
  logic [3:0]  mode;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_aggregator u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_empty_evt_i(tx_evt), .rx_full_evt_i(rx_evt),
    .wdata_i(wdata), .stat_we_i(stat_we), .en_we_i(en_we), .test_we_i(test_we),
    .mode_we_i(mode_we), .status_o(status), .enable_o(enable), .test_o(test),
    .mode_o(mode), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, one posedge passes, sample at next negedge
  task automatic step();
    @(negedge clk);
    stat_we = 0; en_we = 0; test_we = 0; mode_we = 0;
    tx_evt = '0; rx_evt = '0;
  endtask

  task automatic wr(input int sel, input logic [16:0] d);
    wdata = d;
    case (sel)
      0: stat_we = 1;
      1: en_we = 1;
      2: test_we = 1;
      default: mode_we = 1;
    endcase
    step();
  endtask

  task automatic t_reset();
    chk("R10 status", status, 0);
    chk("R10 enable", enable, 0);
    chk("R10 test", test, 0);
    chk("R10 mode", mode, 4);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_events();
    tx_evt = 4'b1000; step();
    chk("R2 tx ch3 bit12", status, 17'h01000);
    rx_evt = 4'b1000; step();
    chk("R2 rx ch3 bit14", status, 17'h05000);
    tx_evt = 4'b0001; rx_evt = 4'b0010; step();
    chk("R2 tx ch0 rx ch1", status, 17'h05041);
    wr(0, 17'h01000);
    chk("R3 partial clear", status, 17'h04041);
    wr(0, 17'h1FFFF);
    chk("R3 full clear", status, 0);
  endtask

  task automatic t_mask_irq();
    wr(1, 17'h1FFFF);
    chk("R5 enable masked", enable, MASK);
    chk("R1 irq low no status", irq, 0);
    tx_evt = 4'b0100; step();
    chk("R1 irq high bit8", irq, 1);
    wr(1, 17'h00001);
    chk("R1 irq low disabled", irq, 0);
    wr(0, 17'h00100);
    wr(1, 17'h0);
  endtask

  task automatic t_priority();
    rx_evt = 4'b0001; step();
    tx_evt = 4'b0010; wdata = 17'h00014; stat_we = 1; step();
    chk("R9 event beats clear", status, 17'h00010);
    wr(0, 17'h1FFFF);
    chk("R9 cleanup", status, 0);
  endtask

  task automatic t_test_force();
    wr(3, 17'h00008);
    chk("R7 mode no force", status, 0);
    wr(2, 17'h00800);
    chk("R6 test forces", status, MASK);
    chk("R5 no bits outside mask", status & ~MASK, 0);
    wr(0, 17'h1FFFF);
    chk("R4 clear blocked", status, MASK);
    wr(2, 17'h0);
    wr(0, 17'h1FFFF);
    chk("R4 clear after exit", status, 0);
    wr(3, 17'h00004);
  endtask

  task automatic t_mode_force();
    wr(2, 17'h00800);
    chk("R6 test no force mode off", status, 0);
    wr(0, 17'h00001);
    wr(3, 17'h0000C);
    chk("R7 mode forces", status, MASK);
    chk("R8 mode value", mode, 4'hC);
    wr(0, 17'h00F00);
    chk("R4 partial clear blocked", status, MASK);
    wr(3, 17'h00004);
    wr(0, 17'h1FFFF);
    chk("R4 clear after mode exit", status, 0);
    wr(2, 17'h0);
  endtask

  task automatic t_widths();
    wr(2, 17'h1F7AB);
    chk("R8 test low 12 bits", test, 12'h7AB);
    wr(3, 17'h1FFF5);
    chk("R8 mode low 4 bits", mode, 4'h5);
    chk("R8 no force side effect", status, 0);
    wr(2, 17'h0);
    wr(3, 17'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_mask_irq();
    t_priority();
    t_test_force();
    t_mode_force();
    t_widths();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule